// File: doc/BRIEF.md
# Sector Transfer Engine with Scan Compare and Overrun Detection

This block runs the execution phase of a sector transfer in a floppy-style disk controller. A command sequencer starts it with an operation code, a size code, a data-length byte and a 3-bit head/unit select. The block works out the sector length. It then raises one data request per byte at a fixed byte period and moves each byte between the host and an external sector buffer. The transfer ends when the last byte is serviced, when terminal count arrives, or when a request waits too long. At the end the block produces three result bytes.

Operation codes are 0 read, 1 write, 2 scan-equal, 3 scan-low-or-equal, 4 scan-high-or-equal and 5 format (a write with a long service window). Codes 6 and 7 act as read. A read shows the buffer byte at the current index on `rd_data`. A write or format stores `host_wdata` at the index. A scan compares the buffer byte (disk) with `host_wdata` (host).

The controller has five states. `S_IDLE` waits for `start`. `S_GAP` holds off until one byte period has passed since the last request. `S_REQ` holds the request open while the data-lost window runs. `S_PAD` zero-fills the rest of a write that was ended early. `S_DONE` is a one-cycle result pulse.

The transitions are:
- start_nonzero: `S_IDLE` to `S_GAP`.
- start_empty: `S_IDLE` to `S_DONE`.
- period_elapsed: `S_GAP` to `S_REQ`.
- byte_taken: `S_REQ` to `S_GAP`.
- last_byte: `S_REQ` to `S_DONE`.
- tc_stop: `S_GAP` or `S_REQ` to `S_DONE`, for reads and scans.
- tc_pad: `S_GAP` or `S_REQ` to `S_PAD`, for writes.
- lost: `S_REQ` to `S_DONE`.
- pad_end: `S_PAD` to `S_DONE`.
- report: `S_DONE` to `S_IDLE`.

Top module: `sector_xfer`

## Requirements
- R1: The length is 128 shifted left by `size_code` when `size_code` is non-zero. When `size_code` is 0, the length is the smaller of `dtl` and 128. A length of 0 completes with no request.
- R2: The first request rises BYTE_CYC cycles after `start` is sampled. While requests are serviced promptly, each later request rises exactly BYTE_CYC cycles after the previous one.
- R3: For a read, `rd_data` shows the buffer byte at the current index while a request is open, and the index starts at 0.
- R4: For a write, each serviced request stores `host_wdata` at the current index and advances the index.
- R5: A scan fails when any compared disk byte violates the criterion: not equal for op 2, greater for op 3, smaller for op 4. A failure sets bit 2 (0x04) of result byte 2 and stays set. Comparisons after the failure are skipped.
- R6: A request left unserviced for BYTE_CYC cycles (FMT_CYC cycles for op 5) ends the transfer with an overrun. On an overrun, result byte 0 bits 7:6 are 01 and result byte 1 bit 4 (0x10) is set.
- R7: `drq` is never high while `drq_mask` is high. Servicing still works while the request is masked.
- R8: Result byte 0 is the upper five status bits with `unit_sel` (latched at start) in bits 2:0. A clean completion gives status bits of zero in all three bytes.
- R9: A write ended early by `tc` writes zero to every remaining byte of the sector and to nothing beyond it.
- R10: A read or scan ended early by `tc` completes normally and raises no further request.
- R11: After reset, `drq`, `busy`, `done` and `med_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled in idle) |
| op | input | 3 | Operation code |
| size_code | input | 3 | Sector size code |
| dtl | input | 8 | Data length used when size code is 0 |
| unit_sel | input | 3 | Head/unit select reported in result byte 0 |
| drq_mask | input | 1 | Suppresses the request output |
| svc | input | 1 | Host/DMA services the open request |
| host_wdata | input | 8 | Host byte for write or scan |
| tc | input | 1 | Terminal count, ends the transfer |
| med_rdata | input | 8 | Buffer byte at `med_addr` |
| rd_data | output | 8 | Byte offered to the host on read |
| drq | output | 1 | Data request |
| busy | output | 1 | Transfer in progress |
| med_addr | output | 15 | Buffer byte index |
| med_we | output | 1 | Buffer write strobe |
| med_wdata | output | 8 | Buffer write byte |
| done | output | 1 | One-cycle completion pulse |
| res0 | output | 8 | Result byte 0 |
| res1 | output | 8 | Result byte 1 |
| res2 | output | 8 | Result byte 2 |

## Verification
The checker watches several properties on every cycle: the mask gate on `drq`, quiet outputs while idle, the unit field and overrun coding of the result, the upper bound on how long a request stays open, and the lower bound on the spacing between requests.

The bench scenarios show what a property cannot. These include the exact sector length in each size mode, the read and write data paths, and the pass or fail outcome of each scan criterion. They also include the zero padding after an early stop on a write, and the exact request count and first-request delay.

// File: rtl/sxfer_pkg.sv
package sxfer_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_SCAN_EQ = 3'd2,
        OP_SCAN_LE = 3'd3,
        OP_SCAN_GE = 3'd4,
        OP_FORMAT  = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } xop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_REQ,
        S_PAD,
        S_DONE
    } xstate_e;

    // status bit positions that downstream result readers decode
    localparam logic [7:0] ST0_ABNORMAL  = 8'h40;
    localparam logic [7:0] ST1_OVERRUN   = 8'h10;
    localparam logic [7:0] ST2_SCAN_MISS = 8'h04;

endpackage

// File: rtl/sxfer_len.sv
module sxfer_len #(
    parameter int LEN_W = 15
) (
    input  logic [2:0]       size_code,
    input  logic [7:0]       dtl,
    output logic [LEN_W-1:0] len
);
    localparam int BASE = 128;

    always_comb begin
        if (size_code == 3'd0) begin
            len = (dtl > 8'(BASE)) ? LEN_W'(BASE) : LEN_W'(dtl);
        end else begin
            len = LEN_W'(BASE) << size_code;
        end
    end
endmodule

// File: rtl/sxfer_timer.sv
module sxfer_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sxfer_scan.sv
module sxfer_scan
    import sxfer_pkg::*;
(
    input  xop_e       op,
    input  logic [7:0] disk_byte,
    input  logic [7:0] host_byte,
    output logic       miss
);
    always_comb begin
        unique case (op)
            OP_SCAN_EQ: miss = (disk_byte != host_byte);
            OP_SCAN_LE: miss = (disk_byte > host_byte);
            OP_SCAN_GE: miss = (disk_byte < host_byte);
            default:    miss = 1'b0;
        endcase
    end
endmodule

// File: rtl/sector_xfer.sv
module sector_xfer
    import sxfer_pkg::*;
#(
    parameter int BYTE_CYC = 32,
    parameter int FMT_CYC  = 4096,
    parameter int LEN_W    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [2:0]       size_code,
    input  logic [7:0]       dtl,
    input  logic [2:0]       unit_sel,
    input  logic             drq_mask,
    input  logic             svc,
    input  logic [7:0]       host_wdata,
    input  logic             tc,
    input  logic [7:0]       med_rdata,
    output logic [7:0]       rd_data,
    output logic             drq,
    output logic             busy,
    output logic [LEN_W-1:0] med_addr,
    output logic             med_we,
    output logic [7:0]       med_wdata,
    output logic             done,
    output logic [7:0]       res0,
    output logic [7:0]       res1,
    output logic [7:0]       res2
);
    localparam int LIM_MAX = (FMT_CYC > BYTE_CYC) ? FMT_CYC : BYTE_CYC;
    localparam int TMR_W   = $clog2(LIM_MAX + 1);

    xstate_e          state, state_n;
    xop_e             op_q;
    logic [LEN_W-1:0] len_q, len_w, idx, idx_n, idx_inc;
    logic             miss_q, miss_n, ovr_q, ovr_n;
    logic [2:0]       unit_q, unit_n;
    logic             pace_load, lost_load, pace_zero, lost_zero;
    logic             cmp_miss, writing, scanning, req_on;
    logic [7:0]       st0_n, st1_n, st2_n;

    sxfer_len #(.LEN_W(LEN_W)) len_i (
        .size_code (size_code),
        .dtl       (dtl),
        .len       (len_w)
    );

    sxfer_timer #(.W(TMR_W)) pace_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pace_load),
        .load_val (TMR_W'(BYTE_CYC - 1)),
        .zero     (pace_zero)
    );

    sxfer_timer #(.W(TMR_W)) lost_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lost_load),
        .load_val ((op_q == OP_FORMAT) ? TMR_W'(FMT_CYC - 1) : TMR_W'(BYTE_CYC - 1)),
        .zero     (lost_zero)
    );

    sxfer_scan scan_i (
        .op        (op_q),
        .disk_byte (med_rdata),
        .host_byte (host_wdata),
        .miss      (cmp_miss)
    );

    assign writing  = (op_q == OP_WRITE) || (op_q == OP_FORMAT);
    assign scanning = (op_q == OP_SCAN_EQ) || (op_q == OP_SCAN_LE) || (op_q == OP_SCAN_GE);
    assign idx_inc  = idx + LEN_W'(1);
    assign req_on   = (state == S_REQ);
    assign unit_n   = (state == S_IDLE && start) ? unit_sel : unit_q;

    // timers: pacing restarts at start and at every request, lost window at every request
    assign lost_load = (state == S_GAP) && pace_zero && !tc;
    assign pace_load = lost_load || ((state == S_IDLE) && start && (len_w != '0));

    // next-state process
    always_comb begin
        state_n = state;
        idx_n   = idx;
        miss_n  = miss_q;
        ovr_n   = ovr_q;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    idx_n   = '0;
                    miss_n  = 1'b0;
                    ovr_n   = 1'b0;
                    state_n = (len_w == '0) ? S_DONE : S_GAP;   // start_empty / start_nonzero
                end
            end
            S_GAP: begin
                if (tc) begin
                    state_n = writing ? S_PAD : S_DONE;         // tc_pad / tc_stop
                end else if (pace_zero) begin
                    state_n = S_REQ;                            // period_elapsed
                end
            end
            S_REQ: begin
                if (svc) begin
                    if (scanning && !miss_q && cmp_miss) begin
                        miss_n = 1'b1;
                    end
                    idx_n = idx_inc;
                    if (idx_inc == len_q) begin
                        state_n = S_DONE;                       // last_byte
                    end else if (tc) begin
                        state_n = writing ? S_PAD : S_DONE;     // tc_pad / tc_stop
                    end else begin
                        state_n = S_GAP;                        // byte_taken
                    end
                end else if (tc) begin
                    state_n = writing ? S_PAD : S_DONE;
                end else if (lost_zero) begin
                    ovr_n   = 1'b1;
                    state_n = S_DONE;                           // lost
                end
            end
            S_PAD: begin
                idx_n = idx_inc;
                if (idx_inc == len_q) begin
                    state_n = S_DONE;                           // pad_end
                end
            end
            S_DONE: begin
                state_n = S_IDLE;                               // report
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        st0_n = ovr_n ? ST0_ABNORMAL : 8'h00;
        st1_n = ovr_n ? ST1_OVERRUN : 8'h00;
        st2_n = miss_n ? ST2_SCAN_MISS : 8'h00;
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_READ;
            len_q  <= '0;
            idx    <= '0;
            miss_q <= 1'b0;
            ovr_q  <= 1'b0;
            unit_q <= 3'd0;
            res0   <= 8'h00;
            res1   <= 8'h00;
            res2   <= 8'h00;
        end else begin
            state  <= state_n;
            idx    <= idx_n;
            miss_q <= miss_n;
            ovr_q  <= ovr_n;
            unit_q <= unit_n;
            if (state == S_IDLE && start) begin
                op_q  <= xop_e'(op);
                len_q <= len_w;
            end
            if (state_n == S_DONE) begin
                res0 <= {st0_n[7:3], unit_n};
                res1 <= st1_n;
                res2 <= st2_n;
            end
        end
    end

    // output process
    always_comb begin
        drq       = req_on && !drq_mask;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        med_addr  = idx;
        med_we    = (req_on && svc && writing) || (state == S_PAD);
        med_wdata = (state == S_PAD) ? 8'h00 : host_wdata;
        rd_data   = req_on ? med_rdata : 8'h00;
    end
endmodule

// File: rtl/sector_xfer_chk.sv
module sector_xfer_chk #(
    parameter int BYTE_CYC = 32,
    parameter int FMT_CYC  = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       drq,
    input logic       drq_mask,
    input logic       done,
    input logic       med_we,
    input logic [2:0] unit_sel,
    input logic [7:0] res0,
    input logic [7:0] res1,
    input logic       req_on
);
    localparam int LIM_MAX = (FMT_CYC > BYTE_CYC) ? FMT_CYC : BYTE_CYC;

    logic [2:0]  unit_lat;
    logic [31:0] req_run;
    logic [31:0] gap_cnt;
    logic        req_d, seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_lat <= 3'd0;
            req_run  <= '0;
            gap_cnt  <= '0;
            req_d    <= 1'b0;
            seen     <= 1'b0;
        end else begin
            if (start && !busy) unit_lat <= unit_sel;
            req_run <= req_on ? req_run + 32'd1 : 32'd0;
            req_d   <= req_on;
            if (req_on && !req_d) begin
                gap_cnt <= 32'd1;
                seen    <= 1'b1;
            end else if (gap_cnt != 32'hFFFF_FFFF) begin
                gap_cnt <= gap_cnt + 32'd1;
            end
        end
    end

    // R7
    drq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drq_mask |-> !drq);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!drq && !med_we));

    // R8
    unit_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res0[2:0] == unit_lat));

    // R6
    ovr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res1[4]) |-> (res0[7:6] == 2'b01));

    // R6
    req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_on |-> (req_run < 32'(LIM_MAX)));

    // R2
    pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_on) && seen) |-> (gap_cnt >= 32'(BYTE_CYC)));
endmodule

bind sector_xfer sector_xfer_chk #(.BYTE_CYC(BYTE_CYC), .FMT_CYC(FMT_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .drq      (drq),
    .drq_mask (drq_mask),
    .done     (done),
    .med_we   (med_we),
    .unit_sel (unit_sel),
    .res0     (res0),
    .res1     (res1),
    .req_on   (req_on)
);

// File: tb/sector_xfer_tb_top.sv
`timescale 1ns/1ps
module sector_xfer_tb_top;
    localparam int BC = 8;
    localparam int FC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, drq_mask = 1'b0, svc = 1'b0, tc = 1'b0;
    logic [2:0]  op = 3'd0, size_code = 3'd0, unit_sel = 3'd0;
    logic [7:0]  dtl = 8'd0, host_wdata = 8'd0;
    logic [7:0]  med_rdata, rd_data, med_wdata, res0, res1, res2;
    logic [14:0] med_addr;
    logic        drq, busy, med_we, done;

    logic [7:0]  mem  [0:1023];
    logic [7:0]  hbuf [0:1023];

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int drq_hi = 0, rises = 0, first_rise = 0, last_rise = 0, min_gap = 0, max_gap = 0;
    int start_cyc = 0, rd_bad = 0;
    logic drq_d = 1'b0;

    typedef struct { logic [7:0] r0, r1, r2; string tag; } exp_t;
    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    sector_xfer #(.BYTE_CYC(BC), .FMT_CYC(FC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size_code(size_code),
        .dtl(dtl), .unit_sel(unit_sel), .drq_mask(drq_mask), .svc(svc),
        .host_wdata(host_wdata), .tc(tc), .med_rdata(med_rdata), .rd_data(rd_data),
        .drq(drq), .busy(busy), .med_addr(med_addr), .med_we(med_we),
        .med_wdata(med_wdata), .done(done), .res0(res0), .res1(res1), .res2(res2)
    );

    assign med_rdata = mem[med_addr[9:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (med_we) mem[med_addr[9:0]] <= med_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // request statistics
    always @(negedge clk) begin
        if (drq) drq_hi++;
        if (drq && !drq_d) begin
            if (rises == 0) first_rise = cyc;
            else begin
                if (rises == 1 || cyc - last_rise < min_gap) min_gap = cyc - last_rise;
                if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
            end
            last_rise = cyc;
            rises++;
        end
        drq_d = drq;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) chk("R8 unexpected done", 1, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " res0"}, {24'd0, res0}, {24'd0, e.r0});
                chk({e.tag, " res1"}, {24'd0, res1}, {24'd0, e.r1});
                chk({e.tag, " res2"}, {24'd0, res2}, {24'd0, e.r2});
            end
        end
    end

    // driver: pushes the expected result, then runs one transfer
    task automatic xfer(input logic [2:0] o, input logic [2:0] n, input logic [7:0] d,
                        input logic [2:0] u, input int tc_at, input bit serve, input bit mask,
                        input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                        input string tag);
        exp_t e;
        int served;
        e.r0 = e0; e.r1 = e1; e.r2 = e2; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        drq_hi = 0; rises = 0; min_gap = 0; max_gap = 0; rd_bad = 0;
        op = o; size_code = n; dtl = d; unit_sel = u; drq_mask = mask;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_cyc = cyc;
        served = 0;
        svc = mask;
        while (busy) begin
            if (!mask) begin
                svc = 1'b0;
                tc = 1'b0;
                if (drq && serve) begin
                    if (o == 3'd0 && rd_data !== mem[served]) rd_bad++;
                    host_wdata = hbuf[served];
                    svc = 1'b1;
                    served++;
                    if (served == tc_at) tc = 1'b1;
                end
            end
            @(negedge clk);
        end
        svc = 1'b0; tc = 1'b0; drq_mask = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            hbuf[i] = 8'(i * 5 + 1);
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 drq", {31'd0, drq}, 0);
        chk("R11 busy", {31'd0, busy}, 0);
        chk("R11 done", {31'd0, done}, 0);
        chk("R11 med_we", {31'd0, med_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: short read, N=0 dtl=6
        xfer(3'd0, 3'd0, 8'd6, 3'd2, -1, 1, 0, 8'h02, 8'h00, 8'h00, "R8 read");
        chk("R1 read len dtl=6", rises, 6);
        chk("R2 first delay", first_rise - start_cyc, BC);
        chk("R2 min gap", min_gap, BC);
        chk("R2 max gap", max_gap, BC);
        chk("R3 read data", rd_bad, 0);

        // R1: dtl above 128 is clipped
        xfer(3'd0, 3'd0, 8'd200, 3'd1, -1, 1, 0, 8'h01, 8'h00, 8'h00, "R8 read clip");
        chk("R1 len min(dtl,128)", rises, 128);
        chk("R3 read data long", rd_bad, 0);

        // R1 R4: write N=1, 256 bytes
        xfer(3'd1, 3'd1, 8'd0, 3'd3, -1, 1, 0, 8'h03, 8'h00, 8'h00, "R8 write");
        chk("R1 len N=1", rises, 256);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== hbuf[i]) bad++;
            chk("R4 write data", bad, 0);
        end

        // R1: zero length
        xfer(3'd0, 3'd0, 8'd0, 3'd4, -1, 1, 0, 8'h04, 8'h00, 8'h00, "R1 zero len");
        chk("R1 zero len no request", rises, 0);

        // R5 scans
        for (int i = 0; i < 4; i++) mem[i] = hbuf[i];
        xfer(3'd2, 3'd0, 8'd4, 3'd0, -1, 1, 0, 8'h00, 8'h00, 8'h00, "R5 eq pass");
        mem[1] = hbuf[1] ^ 8'h01;
        xfer(3'd2, 3'd0, 8'd4, 3'd0, -1, 1, 0, 8'h00, 8'h00, 8'h04, "R5 eq fail");
        for (int i = 0; i < 4; i++) begin mem[i] = 8'd10; hbuf[i] = 8'd20; end
        xfer(3'd3, 3'd0, 8'd4, 3'd1, -1, 1, 0, 8'h01, 8'h00, 8'h00, "R5 le pass");
        mem[2] = 8'd30;
        xfer(3'd3, 3'd0, 8'd4, 3'd1, -1, 1, 0, 8'h01, 8'h00, 8'h04, "R5 le fail");
        for (int i = 0; i < 4; i++) mem[i] = 8'd30;
        xfer(3'd4, 3'd0, 8'd4, 3'd2, -1, 1, 0, 8'h02, 8'h00, 8'h00, "R5 ge pass");
        mem[0] = 8'd10;
        xfer(3'd4, 3'd0, 8'd4, 3'd2, -1, 1, 0, 8'h02, 8'h00, 8'h04, "R5 ge fail");
        for (int i = 0; i < 1024; i++) hbuf[i] = 8'(i * 5 + 1);

        // R6 overrun on read and on format
        xfer(3'd0, 3'd0, 8'd4, 3'd5, -1, 0, 0, 8'h45, 8'h10, 8'h00, "R6 read overrun");
        chk("R6 read window", drq_hi, BC);
        xfer(3'd5, 3'd0, 8'd4, 3'd6, -1, 0, 0, 8'h46, 8'h10, 8'h00, "R6 format overrun");
        chk("R6 format window", drq_hi, FC);

        // R7 masked request still serviced
        xfer(3'd0, 3'd0, 8'd3, 3'd7, -1, 1, 1, 8'h07, 8'h00, 8'h00, "R7 masked");
        chk("R7 drq stays low", drq_hi, 0);

        // R9 early stop on write pads zeros
        for (int i = 0; i < 16; i++) mem[i] = 8'hAA;
        xfer(3'd1, 3'd0, 8'd8, 3'd0, 3, 1, 0, 8'h00, 8'h00, 8'h00, "R9 write tc");
        begin
            int bad = 0;
            for (int i = 0; i < 3; i++) if (mem[i] !== hbuf[i]) bad++;
            for (int i = 3; i < 8; i++) if (mem[i] !== 8'h00) bad++;
            chk("R9 pad content", bad, 0);
            chk("R9 nothing past sector", {24'd0, mem[8]}, 32'hAA);
        end

        // R10 early stop on read
        xfer(3'd0, 3'd0, 8'd8, 3'd3, 2, 1, 0, 8'h03, 8'h00, 8'h00, "R10 read tc");
        chk("R10 requests after tc", rises, 2);

        chk("R8 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule